// File: doc/BRIEF.md
# A/D Conversion Sequencer and Result Register

This block is the digital control for a four-input, 10-bit successive-approximation converter. Software programs two registers over a small byte-wide bus. The control register holds a run bit, a comparator-power bit and a three-bit step-rate code. The input register picks one of the analog inputs. While the run bit is set, the block repeats conversions on the chosen input. Each conversion has a fixed sampling phase followed by ten binary-search steps. On every step the block drives a trial code to the DAC and reads back a single comparator decision.

Each finished conversion is stored in a 10-bit result register. The same register can also be read as its upper eight bits only. A one-cycle interrupt pulse marks every update of the result. The comparator needs time to settle after it is powered. A conversion that begins before that settling time has passed is carried out, but its result is thrown away. The block applies fixed rules when a bus access lands in the same cycle that a conversion ends.

Top module: `adc_seq`

## Requirements
- R1: After reset every register reads 0, `irq` is low, and `cmp_pwr`, `conv_active` and `dac_code` are 0. The control register sits at address 0 and keeps only bit 7 (run), bits 5:3 (step-rate code) and bit 0 (comparator power); its other bits read back as 0. The input register sits at address 1 and keeps its low 2 bits.
- R2: Address 2 reads the 10-bit result. Address 3 reads the result's upper eight bits, result[9:2], zero-extended.
- R3: The block searches from the MSB down. Each trial code is the bits decided so far with the current bit set, and it is driven on `dac_code`. A bit is kept when `cmp_in` is 1, which means the trial code is less than or equal to the input. The stored result is therefore the input code.
- R4: Any write that sets the run bit in an idle block starts a conversion on the next clock edge. The conversion takes SAMPLE_CYC sampling cycles and then 10 steps of 2^(code+1) cycles each. The result and `irq` become visible at the sampling point SAMPLE_CYC + 10·2^(code+1) + 2 falling edges after the write is made.
- R5: While the run bit stays set, conversions follow one another with no gap. Successive `irq` pulses are SAMPLE_CYC + 10·2^(code+1) cycles apart.
- R6: The comparator is stable STAB_CYC cycles after its power bit is set. A conversion that begins before then produces no result write and no `irq`. This covers setting run and power in the same write.
- R7: Writing the power bit first or the input register first gives the same result and the same timing.
- R8: A write to the control or input register during a conversion aborts it. If run is still set, a fresh conversion begins with sampling, with the latency given in R4.
- R9: `irq` is a single-cycle pulse that is high exactly in the first cycle in which the new result is readable.
- R10: If a result read (address 2 or 3) falls in the cycle in which a conversion ends, the read returns the old value. The new result and `irq` appear one cycle later than usual.
- R11: If a control or input register write falls in the cycle in which a conversion ends, that result is dropped, no `irq` is raised, and the result register keeps its old value.
- R12: Clearing both run and power stops all activity: `conv_active`, `cmp_pwr` and `dac_code` go to 0 and no further `irq` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 10 | Read data, combinational from `bus_addr` |
| cmp_in | input | 1 | Comparator decision: 1 when the trial code is less than or equal to the input |
| cmp_pwr | output | 1 | Comparator power enable |
| conv_active | output | 1 | High while sampling or approximating |
| ana_sel | output | 2 | Selected analog input |
| dac_code | output | 10 | Trial code for the DAC; 0 outside the approximation phase |
| irq | output | 1 | Conversion-end pulse |

## Verification
The bench targets the cycle in which a conversion ends. It holds a result read across that cycle, and a design without the one-cycle deferral would raise `irq` one cycle early with the new value already showing. It also fires an input-register write into exactly that cycle, and a design that let the write lose would commit a stale result and pulse `irq`. Setting run and power together checks that the unsettled first conversion is discarded: a sequencer that ignored settling would interrupt a full conversion period early. Exact interrupt latencies across step-rate codes, mid-conversion input changes, and results at the code extremes 0 and 1023 expose errors in the step-length decode, the restart path and the bit search.

// File: rtl/adc_seq_pkg.sv
// Package: shared types and register map constants for the A/D sequencer.
// Assumes an 8-bit register bus with a 2-bit address.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_APPROX = 2'd2
    } sar_state_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_INSEL = 2'd1;
    localparam logic [1:0] ADDR_RES   = 2'd2;
    localparam logic [1:0] ADDR_RESHI = 2'd3;

    localparam int CTRL_RUN_BIT = 7;
    localparam int CTRL_PWR_BIT = 0;
    localparam int CTRL_CODE_LO = 3;
    localparam int CODE_W       = 3;

endpackage

// File: rtl/adc_seq_regs.sv
// Control and input-select registers.
// Decodes bus writes into run / power / step-rate / input fields and flags
// any write to either register so the sequencer can abort.
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic              run,
    output logic              pwr,
    output logic [CODE_W-1:0] code,
    output logic [CH_W-1:0]   insel,
    output logic              cfg_wr
);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // Flag any write that touches configuration.
    assign cfg_wr = wr && (addr == ADDR_CTRL || addr == ADDR_INSEL);

    // Register update on bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            pwr   <= 1'b0;
            code  <= '0;
            insel <= '0;
        end else if (wr && addr == ADDR_CTRL) begin
            run  <= wdata[CTRL_RUN_BIT];
            pwr  <= wdata[CTRL_PWR_BIT];
            code <= wdata[CTRL_CODE_LO +: CODE_W];
        end else if (wr && addr == ADDR_INSEL) begin
            insel <= wdata[CH_W-1:0];
        end
    end

    // R1
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_CTRL) |=> (run == $past(wdata[CTRL_RUN_BIT]) && pwr == $past(wdata[CTRL_PWR_BIT])));
    // R1
    insel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_INSEL) |=> insel == $past(wdata[CH_W-1:0]));

endmodule

// File: rtl/adc_seq_stab.sv
// Comparator settling timer.
// Counts STAB_CYC cycles after power is applied; drops at once when power
// is removed. Assumes STAB_CYC >= 1.
module adc_seq_stab #(
    parameter int STAB_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr,
    output logic stab_ok
);

    localparam int CNT_W = $clog2(STAB_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Count up while powered until the settling time is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr) begin
            cnt     <= '0;
            stab_ok <= 1'b0;
        end else if (!stab_ok) begin
            if (cnt == CNT_W'(STAB_CYC - 1)) stab_ok <= 1'b1;
            else                             cnt     <= cnt + 1'b1;
        end
    end

    // R6
    unpowered_unstable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr |=> !stab_ok);

endmodule

// File: rtl/adc_seq_sar.sv
// Conversion sequencer and successive-approximation search.
// Runs sampling then RES_W binary steps, each 2^(code+1) cycles long, and
// repeats while run stays set. A configuration write aborts to idle.
// Marks a conversion bad when it began before the comparator settled.
module adc_seq_sar
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int SAMPLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cfg_wr,
    input  logic              stab_ok,
    input  logic [CODE_W-1:0] code,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  dac_code,
    output logic              active,
    output logic              done,
    output logic [RES_W-1:0]  done_val,
    output logic              done_bad
);

    localparam int BIT_W     = $clog2(RES_W);
    localparam int STEP_LOG2 = (1 << CODE_W) + 1;
    localparam int SMP_W     = $clog2(SAMPLE_CYC + 1);
    localparam int CNT_W     = (SMP_W > STEP_LOG2) ? SMP_W + 1 : STEP_LOG2 + 1;

    sar_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bidx;
    logic [RES_W-1:0] acc;
    logic             bad;
    logic [CNT_W-1:0] step_last;
    logic [RES_W-1:0] trial;
    logic [RES_W-1:0] acc_next;
    logic             last_step;

    // Step length decode: 2^(code+1) cycles per binary step.
    always_comb step_last = (CNT_W'(1) << ({1'b0, code} + 4'd1)) - CNT_W'(1);

    // Trial code and comparator-driven next partial result.
    assign trial     = acc | (RES_W'(1) << bidx);
    assign acc_next  = cmp_in ? trial : acc;
    assign last_step = (cnt == step_last);

    assign dac_code = (state == ST_APPROX) ? trial : '0;
    assign active   = (state != ST_IDLE);
    assign done     = (state == ST_APPROX) && last_step && (bidx == '0);
    assign done_val = acc_next;
    assign done_bad = bad;

    // Phase sequencing and bit search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            acc   <= '0;
            bad   <= 1'b0;
        end else if (cfg_wr || !run) begin
            state <= ST_IDLE;
            cnt   <= '0;
            acc   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    state <= ST_SAMPLE;
                    cnt   <= '0;
                    acc   <= '0;
                    bad   <= !stab_ok;
                end
                ST_SAMPLE: begin
                    if (cnt == CNT_W'(SAMPLE_CYC - 1)) begin
                        state <= ST_APPROX;
                        cnt   <= '0;
                        bidx  <= BIT_W'(RES_W - 1);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_APPROX: begin
                    if (last_step) begin
                        cnt <= '0;
                        if (bidx == '0) begin
                            state <= ST_SAMPLE;
                            acc   <= '0;
                            bad   <= !stab_ok;
                        end else begin
                            acc  <= acc_next;
                            bidx <= bidx - 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> state == ST_IDLE);
    // R12
    stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !active);
    // R3
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_APPROX) |-> bidx == BIT_W'(RES_W - 1));
    // R4
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE && run && !cfg_wr && cnt != CNT_W'(SAMPLE_CYC - 1)) |=> state == ST_SAMPLE);

endmodule

// File: rtl/adc_seq_result.sv
// Result register and conversion-end interrupt.
// Commits a finished, valid conversion unless a configuration write lands
// in the same cycle; defers the commit one cycle when a result read lands
// in that cycle. Assumes conversions are at least three cycles apart.
module adc_seq_result #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [RES_W-1:0] done_val,
    input  logic             done_bad,
    input  logic             cfg_wr,
    input  logic             rd_res,
    output logic [RES_W-1:0] result,
    output logic             irq
);

    logic             pend;
    logic [RES_W-1:0] pend_val;
    logic             commit_ok;

    assign commit_ok = done && !cfg_wr && !done_bad;

    // Result commit with read deferral and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            irq      <= 1'b0;
            pend     <= 1'b0;
            pend_val <= '0;
        end else begin
            irq  <= 1'b0;
            pend <= 1'b0;
            if (pend) begin
                result <= pend_val;
                irq    <= 1'b1;
            end else if (commit_ok && rd_res) begin
                pend     <= 1'b1;
                pend_val <= done_val;
            end else if (commit_ok) begin
                result <= done_val;
                irq    <= 1'b1;
            end
        end
    end

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R9
    result_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result)) |-> irq);
    // R11
    cfg_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_wr) |=> (!irq && $stable(result)));
    // R6
    bad_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_bad) |=> !irq);
    // R10
    read_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ok && rd_res) |=> (!irq && $stable(result)));
    // R10
    read_late_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ok && rd_res) |-> ##2 irq);

endmodule

// File: rtl/adc_seq.sv
// Top of the A/D conversion sequencer.
// Ties register file, settling timer, search sequencer and result stage to
// a byte-wide register bus; read data is combinational from the address.
// Assumes RES_W >= 8 and N_CH a power of two.
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int N_CH       = 4,
    parameter int SAMPLE_CYC = 4,
    parameter int STAB_CYC   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [1:0]              bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [RES_W-1:0]        bus_rdata,
    input  logic                    cmp_in,
    output logic                    cmp_pwr,
    output logic                    conv_active,
    output logic [$clog2(N_CH)-1:0] ana_sel,
    output logic [RES_W-1:0]        dac_code,
    output logic                    irq
);

    localparam int CH_W = $clog2(N_CH);
    localparam int HI_W = 8;

    logic              run;
    logic              pwr;
    logic [CODE_W-1:0] code;
    logic [CH_W-1:0]   insel;
    logic              cfg_wr;
    logic              stab_ok;
    logic              done;
    logic [RES_W-1:0]  done_val;
    logic              done_bad;
    logic [RES_W-1:0]  result;
    logic              rd_res;

    adc_seq_regs #(.CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .run(run), .pwr(pwr), .code(code), .insel(insel), .cfg_wr(cfg_wr)
    );

    adc_seq_stab #(.STAB_CYC(STAB_CYC)) u_stab (
        .clk(clk), .rst_n(rst_n), .pwr(pwr), .stab_ok(stab_ok)
    );

    adc_seq_sar #(.RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC)) u_sar (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_wr(cfg_wr), .stab_ok(stab_ok),
        .code(code), .cmp_in(cmp_in), .dac_code(dac_code), .active(conv_active),
        .done(done), .done_val(done_val), .done_bad(done_bad)
    );

    adc_seq_result #(.RES_W(RES_W)) u_result (
        .clk(clk), .rst_n(rst_n), .done(done), .done_val(done_val),
        .done_bad(done_bad), .cfg_wr(cfg_wr), .rd_res(rd_res),
        .result(result), .irq(irq)
    );

    assign rd_res  = bus_rd && (bus_addr == ADDR_RES || bus_addr == ADDR_RESHI);
    assign cmp_pwr = pwr;
    assign ana_sel = insel;

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = RES_W'({run, 1'b0, code, 2'b00, pwr});
            ADDR_INSEL: bus_rdata = RES_W'(insel);
            ADDR_RES:   bus_rdata = result;
            default:    bus_rdata = RES_W'(result[RES_W-1 -: HI_W]);
        endcase
    end

endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SMP        = 4;
    localparam int STAB       = 8;
    localparam int LIMIT      = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [9:0] bus_rdata;
    logic       cmp_in;
    logic       cmp_pwr;
    logic       conv_active;
    logic [1:0] ana_sel;
    logic [9:0] dac_code;
    logic       irq;

    logic [9:0] vin [0:3];

    int checks = 0;
    int errors = 0;

    adc_seq u_adc_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_in(cmp_in), .cmp_pwr(cmp_pwr), .conv_active(conv_active),
        .ana_sel(ana_sel), .dac_code(dac_code), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Comparator model: trial code at or below the held input keeps the bit.
    assign cmp_in = (dac_code <= vin[ana_sel]);

    function automatic int conv_len(input int code);
        return SMP + 10 * (2 << code);
    endfunction

    function automatic int start_lat(input int code);
        return conv_len(code) + 2;
    endfunction

    function automatic int hi_of(input int v);
        return v >> 2;
    endfunction

    function automatic logic [7:0] ctrl(input bit run, input int code, input bit pwr);
        return {run, 1'b0, 3'(code), 2'b00, pwr};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output int v);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        v = int'(bus_rdata);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic wait_irq(input string tag, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < LIMIT);
        if (!irq) check(1'b0, tag, n, -1);
    endtask

    task automatic idle_cycles(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    // Global watchdog.
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, n, n2, old, prev, irq_seen, ch, code;
        vin[0] = 10'd0; vin[1] = 10'd0; vin[2] = 10'd0; vin[3] = 10'd0;
        void'($urandom(32'd7321));

        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        rd_reg(2'd0, v); check(v == 0, "R1 ctrl reset", v, 0);
        rd_reg(2'd1, v); check(v == 0, "R1 insel reset", v, 0);
        rd_reg(2'd2, v); check(v == 0, "R2 result reset", v, 0);
        check(irq == 1'b0, "R1 irq reset", int'(irq), 0);
        check(conv_active == 1'b0 && cmp_pwr == 1'b0 && dac_code == 0, "R1 outputs reset",
              int'({conv_active, cmp_pwr}), 0);

        // Register read-back masks.
        wr_reg(2'd0, 8'h7E);
        rd_reg(2'd0, v); check(v == 8'h38, "R1 ctrl mask", v, 8'h38);
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd1, v); check(v == 3, "R1 insel mask", v, 3);
        wr_reg(2'd0, 8'h00);

        // Order A: input first, then power, then run.
        vin[2] = 10'd613;
        wr_reg(2'd1, 8'd2);
        wr_reg(2'd0, ctrl(0, 0, 1));
        check(cmp_pwr == 1'b1, "R1 power bit", int'(cmp_pwr), 1);
        idle_cycles(STAB + 4);
        wr_reg(2'd0, ctrl(1, 0, 1));
        wait_irq("R4 timeout", n);
        check(n == start_lat(0), "R4 latency code0", n, start_lat(0));
        rd_reg(2'd2, v); check(v == 613, "R3 result", v, 613);
        rd_reg(2'd3, v); check(v == hi_of(613), "R2 high byte", v, hi_of(613));
        @(negedge clk);
        check(irq == 1'b0, "R9 single pulse", int'(irq), 0);

        // Back-to-back repetition.
        vin[2] = 10'd77;
        wait_irq("R5 timeout", n2);
        check(n2 == conv_len(0) - 1, "R5 repeat period", n2 + 1, conv_len(0));
        rd_reg(2'd2, v); check(v == 77, "R5 repeat result", v, 77);
        wr_reg(2'd0, 8'h00);

        // Order B: power first, then input, then run.
        vin[2] = 10'd613;
        wr_reg(2'd0, ctrl(0, 0, 1));
        wr_reg(2'd1, 8'd2);
        idle_cycles(STAB + 4);
        wr_reg(2'd0, ctrl(1, 0, 1));
        wait_irq("R7 timeout", n2);
        check(n2 == n, "R7 order latency", n2, n);
        rd_reg(2'd2, v); check(v == 613, "R7 order result", v, 613);
        wr_reg(2'd0, 8'h00);

        // Run and power in one write: first conversion discarded.
        vin[2] = 10'd300;
        wr_reg(2'd0, ctrl(1, 0, 1));
        wait_irq("R6 timeout", n);
        check(n == 2 * conv_len(0) + 2, "R6 unsettled dropped", n, 2 * conv_len(0) + 2);
        rd_reg(2'd2, v); check(v == 300, "R6 result", v, 300);
        wr_reg(2'd0, ctrl(0, 1, 1));

        // Mid-conversion input change restarts.
        vin[1] = 10'd111; vin[3] = 10'd888;
        wr_reg(2'd1, 8'd1);
        wr_reg(2'd0, ctrl(1, 1, 1));
        idle_cycles(15);
        check(irq == 1'b0, "R8 no early irq", int'(irq), 0);
        wr_reg(2'd1, 8'd3);
        wait_irq("R8 timeout", n);
        check(n == start_lat(1), "R8 restart latency", n, start_lat(1));
        rd_reg(2'd2, v); check(v == 888, "R8 restart result", v, 888);
        wr_reg(2'd0, ctrl(0, 0, 1));

        // Read in the ending cycle defers the write.
        rd_reg(2'd2, old);
        vin[0] = 10'(old ^ 32'h155);
        wr_reg(2'd1, 8'd0);
        wr_reg(2'd0, ctrl(1, 0, 1));
        bus_addr = 2'd2;
        bus_rd   = 1'b1;
        n = 0;
        prev = old;
        do begin
            @(negedge clk);
            n++;
            if (!irq) prev = int'(bus_rdata);
        end while (!irq && n < LIMIT);
        check(n == start_lat(0) + 1, "R10 deferred irq", n, start_lat(0) + 1);
        check(prev == old, "R10 old value read", prev, old);
        check(int'(bus_rdata) == int'(vin[0]), "R10 new value", int'(bus_rdata), int'(vin[0]));
        bus_rd = 1'b0;
        wr_reg(2'd0, ctrl(0, 0, 1));

        // Config write in the ending cycle cancels the result.
        rd_reg(2'd2, old);
        vin[1] = 10'(old ^ 32'h2AA);
        wr_reg(2'd1, 8'd1);
        wr_reg(2'd0, ctrl(1, 0, 1));
        irq_seen = 0;
        for (int k = 1; k < start_lat(0); k++) begin
            @(negedge clk);
            if (irq) irq_seen++;
        end
        check(irq_seen == 0, "R11 no irq before end", irq_seen, 0);
        bus_addr  = 2'd1;
        bus_wdata = 8'd1;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        rd_reg(2'd2, v); check(v == old, "R11 result kept", v, old);
        wait_irq("R11 timeout", n);
        check(n == start_lat(0), "R11 dropped then restarted", n, start_lat(0));
        rd_reg(2'd2, v); check(v == int'(vin[1]), "R11 later result", v, int'(vin[1]));

        // Stop everything.
        wr_reg(2'd0, 8'h00);
        @(negedge clk);
        check(conv_active == 1'b0, "R12 inactive", int'(conv_active), 0);
        check(cmp_pwr == 1'b0, "R12 power off", int'(cmp_pwr), 0);
        check(dac_code == 0, "R12 dac idle", int'(dac_code), 0);
        irq_seen = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (irq || conv_active) irq_seen++;
        end
        check(irq_seen == 0, "R12 quiet", irq_seen, 0);

        // Random conversions plus code extremes.
        wr_reg(2'd0, ctrl(0, 0, 1));
        idle_cycles(STAB + 4);
        for (int it = 0; it < 24; it++) begin
            ch   = int'($urandom % 4);
            code = int'($urandom % 3);
            if (it == 0)      vin[ch] = 10'd0;
            else if (it == 1) vin[ch] = 10'd1023;
            else              vin[ch] = 10'($urandom % 1024);
            wr_reg(2'd0, ctrl(0, code, 1));
            wr_reg(2'd1, 8'(ch));
            wr_reg(2'd0, ctrl(1, code, 1));
            wait_irq("R4 random timeout", n);
            check(n == start_lat(code), "R4 random latency", n, start_lat(code));
            rd_reg(2'd2, v); check(v == int'(vin[ch]), "R3 random result", v, int'(vin[ch]));
            rd_reg(2'd3, v); check(v == hi_of(int'(vin[ch])), "R2 random high byte", v, hi_of(int'(vin[ch])));
        end
        wr_reg(2'd0, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule